// File: doc/BRIEF.md
# 32-Pin I/O Port with Atomic Set/Clear Configuration

This block is a general-purpose I/O port of up to 32 pins. Software reaches it through a simple word-wide register bus: an address, a write strobe, write data and combinational read data. Each of seven per-pin configuration words (output data, interrupt mask, pull control, function enable, select, direction and trigger) has three addresses. The first is a read-only view of the word, the second sets bits and the third clears bits. Software can therefore change one pin without a read-modify-write sequence, and no other pin is disturbed.

From the configuration bits the block derives, per pin, the output value and output enable, a pull-disable control, a two-bit alternate-function code, and an armed flag for pins placed in interrupt mode. The pin levels coming in from the pads pass through a two-flop synchroniser and can be read back at offset 0x00. The pads, edge and level detection, and any bus bridge are outside this block.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset every configuration word reads 0, except the pull word, which reads all ones over the implemented pins. Every pin is then a plain input: pin_oe = 0, pin_out = 0 and alt_sel = 0.
- R2: A write to base+0x4 of a configuration word ORs the write data into that word. Bits written as 0 keep their value.
- R3: A write to base+0x8 of a configuration word clears exactly the bits written as 1.
- R4: Writes to a base address, including 0x00, change nothing. Reads of a set or clear alias, and of any unmapped address, return 0.
- R5: The configuration words read back at these base offsets: data 0x10, mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70.
- R6: Offset 0x00 returns the pin levels after two clock edges of synchronisation.
- R7: A pin with function=0, select=0 and direction=1 drives pin_oe=1 and pin_out equal to its data bit. Every other pin drives pin_oe=0 and pin_out=0.
- R8: alt_sel[2i+1:2i] encodes the pin mode. With function=0 it is 00. With function=1 it is 01 if select=0, 10 if select=1 and trigger=0, and 11 if select=1 and trigger=1.
- R9: pull_off[i] equals pull bit i. A value of 1 means the pull-up is off.
- R10: A pin with function=0 and select=1 is in interrupt mode. Its output enable is 0, and irq_armed[i] is 1 exactly when its mask bit is 0.
- R11: Bits at or above IMPL_PINS read as 0, ignore writes, and drive 0 on every per-pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| pull_off | output | 32 | Per-pin pull-up disable |
| alt_sel | output | 64 | Two-bit mode code per pin |
| irq_armed | output | 32 | Pin is in interrupt mode and unmasked |

## Verification
The bench sets and clears overlapping bit patterns so that a design which overwrote the word on an alias write, instead of ORing or masking it, would lose the bits of neighbouring pins. It writes all-ones to base addresses and reads the aliases, which catches a decode that treats a base write as a store or returns live data on alias reads. The bench walks pins through GPIO, interrupt and all three alternate codes, where a swapped select/trigger decode or an output enable left on in interrupt mode shows up at once. It also drives the top, unimplemented pin and checks the read-back one and two edges after an input change, exposing a wrong synchroniser depth or a leaking upper bit.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  localparam int WORD_W    = 32;
  localparam int GRP_COUNT = 8;

  // Register group, taken from address bits [6:4]
  typedef enum logic [2:0] {
    GRP_LEVEL = 3'd0,
    GRP_DATA  = 3'd1,
    GRP_MASK  = 3'd2,
    GRP_PULL  = 3'd3,
    GRP_FUNC  = 3'd4,
    GRP_SEL   = 3'd5,
    GRP_DIR   = 3'd6,
    GRP_TRIG  = 3'd7
  } grp_e;

  // Access kind, taken from address bits [3:2]
  typedef enum logic [1:0] {
    ACC_READ = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_NONE = 2'd3
  } acc_e;

  typedef struct packed {
    logic hit;
    grp_e grp;
    acc_e acc;
  } dec_t;

  function automatic logic [WORD_W-1:0] low_ones(input int n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/gpio_cfg_word.sv
module gpio_cfg_word #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         upd;
  logic [W-1:0] eff;

  always_comb begin
    eff   = wdata & IMPL_MASK;
    upd   = set_en | clr_en;
    q_nxt = q;
    if (set_en) q_nxt = q_nxt | eff;
    if (clr_en) q_nxt = q_nxt & ~eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RESET_VAL & IMPL_MASK;
    else if (upd) q <= q_nxt;
  end

  // R2: bits written through the set alias are 1 afterwards
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wdata & IMPL_MASK)) == $past(wdata & IMPL_MASK)));
  // R3: bits written through the clear alias are 0 afterwards
  p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wdata)) == '0));
  // R4: without an alias write the word holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(q));
endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int           W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  logic [W-1:0] meta_nxt;
  logic [1:0]   age;
  logic [1:0]   age_nxt;

  always_comb begin
    meta_nxt = d & IMPL_MASK;
    age_nxt  = (age == 2'd2) ? age : age + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
      age  <= '0;
    end else begin
      meta <= meta_nxt;
      q    <= meta;
      age  <= age_nxt;
    end
  end

  // R6: the output is the input of two edges earlier
  p_two_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == ($past(d, 2) & IMPL_MASK)));
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode #(
  parameter int W = 32
) (
  input  logic [W-1:0]   data_q,
  input  logic [W-1:0]   mask_q,
  input  logic [W-1:0]   pull_q,
  input  logic [W-1:0]   func_q,
  input  logic [W-1:0]   sel_q,
  input  logic [W-1:0]   dir_q,
  input  logic [W-1:0]   trig_q,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe,
  output logic [W-1:0]   pull_off,
  output logic [2*W-1:0] alt_sel,
  output logic [W-1:0]   irq_armed
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic plain_io;
    logic irq_mode;
    logic [1:0] code;

    always_comb begin
      plain_io = ~func_q[i] & ~sel_q[i];
      irq_mode = ~func_q[i] &  sel_q[i];
      if (!func_q[i])     code = 2'b00;
      else if (!sel_q[i]) code = 2'b01;
      else if (!trig_q[i]) code = 2'b10;
      else                code = 2'b11;
    end

    assign pin_oe[i]          = plain_io & dir_q[i];
    assign pin_out[i]         = plain_io & dir_q[i] & data_q[i];
    assign pull_off[i]        = pull_q[i];
    assign alt_sel[2*i+1:2*i] = code;
    assign irq_armed[i]       = irq_mode & ~mask_q[i];
  end
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IMPL_PINS = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [WORD_W-1:0]   pin_in,
  output logic [WORD_W-1:0]   pin_out,
  output logic [WORD_W-1:0]   pin_oe,
  output logic [WORD_W-1:0]   pull_off,
  output logic [2*WORD_W-1:0] alt_sel,
  output logic [WORD_W-1:0]   irq_armed
);
  localparam logic [WORD_W-1:0] IMPL_MASK = low_ones(IMPL_PINS);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // address decode
  dec_t dec;
  always_comb begin
    dec.hit = (bus_addr[ADDR_W-1:7] == '0) && (bus_addr[1:0] == 2'b00);
    dec.grp = grp_e'(bus_addr[6:4]);
    dec.acc = acc_e'(bus_addr[3:2]);
  end

  logic [WORD_W-1:0] cfg_q [GRP_COUNT];
  logic [WORD_W-1:0] level_q;

  for (genvar g = 0; g < GRP_COUNT; g++) begin : g_word
    if (g == 0) begin : g_level_slot
      assign cfg_q[g] = '0;
    end else begin : g_cfg
      logic set_en;
      logic clr_en;
      assign set_en = bus_we && dec.hit && (dec.grp == grp_e'(g)) && (dec.acc == ACC_SET);
      assign clr_en = bus_we && dec.hit && (dec.grp == grp_e'(g)) && (dec.acc == ACC_CLR);
      gpio_cfg_word #(
        .W        (WORD_W),
        .RESET_VAL((g == int'(GRP_PULL)) ? '1 : '0),
        .IMPL_MASK(IMPL_MASK)
      ) u_word (
        .clk   (clk),
        .rst_n (rst_s),
        .set_en(set_en),
        .clr_en(clr_en),
        .wdata (bus_wdata),
        .q     (cfg_q[g])
      );
    end
  end

  gpio_level_sync #(
    .W        (WORD_W),
    .IMPL_MASK(IMPL_MASK)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_s),
    .d    (pin_in),
    .q    (level_q)
  );

  gpio_pin_mode #(
    .W(WORD_W)
  ) u_mode (
    .data_q   (cfg_q[GRP_DATA]),
    .mask_q   (cfg_q[GRP_MASK]),
    .pull_q   (cfg_q[GRP_PULL]),
    .func_q   (cfg_q[GRP_FUNC]),
    .sel_q    (cfg_q[GRP_SEL]),
    .dir_q    (cfg_q[GRP_DIR]),
    .trig_q   (cfg_q[GRP_TRIG]),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pull_off (pull_off),
    .alt_sel  (alt_sel),
    .irq_armed(irq_armed)
  );

  // read path
  always_comb begin
    bus_rdata = '0;
    if (dec.hit && (dec.acc == ACC_READ)) begin
      if (dec.grp == GRP_LEVEL) bus_rdata = level_q;
      else                      bus_rdata = cfg_q[dec.grp];
    end
  end

  logic [7*WORD_W-1:0] cfg_flat;
  assign cfg_flat = {cfg_q[1], cfg_q[2], cfg_q[3], cfg_q[4], cfg_q[5], cfg_q[6], cfg_q[7]};

  // R4: a write to a base address leaves every word unchanged
  p_base_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_we && dec.hit && (dec.acc == ACC_READ)) |=> $stable(cfg_flat));
  // R7: setting function bits removes output drive on those pins
  p_func_blocks_oe_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_we && dec.hit && (dec.grp == GRP_FUNC) && (dec.acc == ACC_SET))
      |=> ((pin_oe & $past(bus_wdata)) == '0));
  // R10: setting mask bits disarms those pins
  p_mask_disarms_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_we && dec.hit && (dec.grp == GRP_MASK) && (dec.acc == ACC_SET))
      |=> ((irq_armed & $past(bus_wdata)) == '0));
  // R11: unimplemented bits never read back as 1
  p_upper_bits_zero_r11: assert property (@(posedge clk) disable iff (!rst_s)
    ((bus_rdata & ~IMPL_MASK) == '0) && ((pin_oe & ~IMPL_MASK) == '0));
endmodule

// File: tb/sim_gpio_alias_port.sv
module sim_gpio_alias_port;
  localparam int IMPL = 31;
  localparam logic [31:0] IMSK = 32'h7FFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pull_off;
  logic [63:0] alt_sel;
  logic [31:0] irq_armed;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  gpio_alias_port #(.ADDR_W(8), .IMPL_PINS(IMPL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_off(pull_off),
    .alt_sel(alt_sel), .irq_armed(irq_armed)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] m_reg [8];
  logic [31:0] m_s1, m_s2;
  logic        m_rs1, m_rs2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rs1 <= 1'b0; m_rs2 <= 1'b0; end
    else        begin m_rs1 <= 1'b1; m_rs2 <= m_rs1; end
  end

  always @(posedge clk or negedge rst_n) begin
    int g;
    if (!rst_n || !m_rs2) begin
      for (int k = 0; k < 8; k++) m_reg[k] <= (k == 3) ? IMSK : 32'h0;
      m_s1 <= '0;
      m_s2 <= '0;
    end else begin
      m_s1 <= pin_in & IMSK;
      m_s2 <= m_s1;
      if (bus_we && !bus_addr[7] && bus_addr[1:0] == 2'b00) begin
        g = int'(bus_addr[6:4]);
        if (g != 0 && bus_addr[3:2] == 2'd1) m_reg[g] <= m_reg[g] | (bus_wdata & IMSK);
        if (g != 0 && bus_addr[3:2] == 2'd2) m_reg[g] <= m_reg[g] & ~(bus_wdata & IMSK);
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[7] || a[1:0] != 2'b00 || a[3:2] != 2'd0) return 32'h0;
    if (a[6:4] == 3'd0) return m_s2;
    return m_reg[a[6:4]];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of every output against the model
  always @(posedge clk) begin
    logic [31:0] e_out, e_oe, e_arm;
    logic [63:0] e_alt;
    #5;
    if (m_rs2 && !done) begin
      for (int i = 0; i < 32; i++) begin
        logic f, s, d, t;
        f = m_reg[4][i]; s = m_reg[5][i]; d = m_reg[6][i]; t = m_reg[7][i];
        e_oe[i]  = !f && !s && d;
        e_out[i] = e_oe[i] && m_reg[1][i];
        e_arm[i] = !f && s && !m_reg[2][i];
        e_alt[2*i +: 2] = !f ? 2'd0 : (!s ? 2'd1 : (!t ? 2'd2 : 2'd3));
      end
      chk("R7 pin_oe",     {32'h0, pin_oe},    {32'h0, e_oe});
      chk("R7 pin_out",    {32'h0, pin_out},   {32'h0, e_out});
      chk("R8 alt_sel",    alt_sel,            e_alt);
      chk("R9 pull_off",   {32'h0, pull_off},  {32'h0, m_reg[3]});
      chk("R10 irq_armed", {32'h0, irq_armed}, {32'h0, e_arm});
      chk("R5 bus_rdata",  {32'h0, bus_rdata}, {32'h0, m_read(bus_addr)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #5;
    chk(req, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic settle();
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h04;
    @(posedge clk); #5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    do_reset();

    // R1: reset values
    rd(8'h10, 32'h0, "R1 data");
    rd(8'h30, IMSK,  "R1 pull");
    rd(8'h40, 32'h0, "R1 func");
    rd(8'h60, 32'h0, "R1 dir");
    chk("R1 pin_oe",  {32'h0, pin_oe}, 64'h0);
    chk("R1 alt_sel", alt_sel, 64'h0);

    // R2 / R3: set and clear aliases on data
    wr(8'h14, 32'h0000_00F0);
    wr(8'h14, 32'h0000_000F);
    rd(8'h10, 32'h0000_00FF, "R2 set ORs");
    wr(8'h18, 32'h0000_003C);
    rd(8'h10, 32'h0000_00C3, "R3 clear masks");

    // R4: base writes ignored, alias reads zero
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0000_00C3, "R4 base write");
    rd(8'h14, 32'h0, "R4 set alias read");
    rd(8'h18, 32'h0, "R4 clear alias read");
    rd(8'h8C, 32'h0, "R4 unmapped read");

    // R7: plain outputs
    wr(8'h64, 32'h0000_00FF);
    settle();
    chk("R7 oe",  {32'h0, pin_oe},  {32'h0, 32'h0000_00FF});
    chk("R7 out", {32'h0, pin_out}, {32'h0, 32'h0000_00C3});

    // R8: alternate function codes on pins 0..3
    wr(8'h44, 32'h0000_000F);
    wr(8'h54, 32'h0000_000C);
    wr(8'h74, 32'h0000_0008);
    settle();
    chk("R8 codes", {56'h0, alt_sel[7:0]}, {56'h0, 8'b11_10_01_01});
    chk("R7 oe after func", {32'h0, pin_oe}, {32'h0, 32'h0000_00F0});

    // R10: interrupt mode on pins 4,5
    wr(8'h54, 32'h0000_0030);
    settle();
    chk("R10 armed", {32'h0, irq_armed}, {32'h0, 32'h0000_0030});
    chk("R10 oe",    {32'h0, pin_oe},    {32'h0, 32'h0000_00C0});
    wr(8'h24, 32'h0000_0010);
    settle();
    chk("R10 masked", {32'h0, irq_armed}, {32'h0, 32'h0000_0020});

    // R9: pull control
    wr(8'h38, 32'h0000_FFFF);
    settle();
    chk("R9 pull_off", {32'h0, pull_off}, {32'h0, 32'h7FFF_0000});

    // R11: unimplemented top bit
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h64, 32'h8000_0000);
    rd(8'h10, 32'h7FFF_FFFF, "R11 data top bit");
    chk("R11 oe top bit", {63'h0, pin_oe[31]}, 64'h0);

    // R6: synchroniser depth
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; pin_in = 32'hA5A5_1234;
    @(posedge clk); #5;
    chk("R6 one edge", {32'h0, bus_rdata}, 64'h0);
    @(posedge clk); #5;
    chk("R6 two edges", {32'h0, bus_rdata}, {32'h0, 32'h25A5_1234});

    // mixed traffic compared against the model each clock
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      @(negedge clk);
      bus_addr  = {1'b0, lfsr[2:0], lfsr[4:3], 2'b00};
      bus_we    = lfsr[5];
      bus_wdata = {lfsr[15:0], lfsr[31:16]} ^ {lfsr[7:0], 24'h0};
      if (lfsr[9:8] == 2'b00) pin_in = lfsr ^ 32'h5A5A_5A5A;
    end

    // R1: a second reset restores the defaults
    do_reset();
    rd(8'h30, IMSK,  "R1 pull again");
    rd(8'h10, 32'h0, "R1 data again");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule